// File: doc/BRIEF.md
# Ethernet Interrupt Status Aggregator

This block gathers the interrupt sources of a network controller into one sticky status register and drives a single host interrupt line. Six event inputs each take a one-cycle pulse: transmit overflow, transmit done, MAC event, early receive, receive done and receive reject. A software command can also force an interrupt. Each status bit has an enable bit in a mask register. The masked request passes a global enable and a global mask. It can then be held in a service flag that waits for the host to acknowledge it. Finally it is driven as a level or as a one-cycle edge pulse.

The host uses a plain register port: a 3-bit address, a write strobe with 8-bit write data, and read data that follows the address combinationally. Writes take effect on the clock edge that samples them. Every register value and the interrupt line reflect that write from the same edge onward. There is no data stream, so no valid/ready handshake and no back-pressure: the port accepts a write on every cycle.

Register map:

| Addr | Name | Access | Meaning |
|---|---|---|---|
| 0 | STATUS | read, write 1 to clear | sticky source bits |
| 1 | ENABLE | read/write | 1 lets the matching status bit request |
| 2 | COMMAND | write, bit 2 reads back | bit 2 global enable, bit 3 force |
| 3 | GLOBAL | bit 0 read only, bit 1 read/write | bit 0 pending, bit 1 global mask |
| 4 | CONFIG | read/write | bit 0 level mode, bit 1 acknowledge required |
| 5 | SERVICE | read, write 1 to clear | bit 0 service flag |

Top module: `eth_irq_aggregator`

## Requirements
- R1: After reset, every register reads 0. Interrupts are globally disabled, the line uses edge mode without acknowledge, and `irq_o` is low.
- R2: An event pulse sets its status bit on the next clock edge: transmit overflow bit 0, transmit done bit 1, MAC event bit 2, early receive bit 4, receive done bit 5, receive reject bit 6. Bit 7 records a forced interrupt. Bit 3 always reads 0.
- R3: Status bits stay set until the host writes 1 to them at address 0. Writing 0 leaves a bit alone. When an event and a clear reach the same bit in the same cycle, the bit ends up set.
- R4: The enable register at address 1 reads back what was written, with bit 3 always 0. GLOBAL bit 0 reads 1 exactly when the global enable is set and some status bit has its enable bit set.
- R5: A write to address 2 stores data bit 2 as the global enable, which reads back in bit 2. If data bit 3 is 1, the same write also sets status bit 7. No other bit of a command write has any effect.
- R6: GLOBAL bit 1 is a read/write mask. While it is 1, the host request is held low, and `irq_o` stays low whenever acknowledge is not required.
- R7: In level mode (CONFIG bit 0 = 1) without acknowledge, `irq_o` equals the host request (pending and not globally masked) from the edge on which the request changes.
- R8: In edge mode (CONFIG bit 0 = 0), `irq_o` is high for exactly one cycle when the request rises. It gives no second pulse while the request stays high.
- R9: With CONFIG bit 1 = 1, the service flag (SERVICE bit 0) sets on the edge after the host request is seen. It stays set after the status is cleared, until the host writes 1 to SERVICE bit 0, and the flag replaces the host request as the input to the line driver. With CONFIG bit 1 = 0, the flag reads 0.
- R10: Writes to addresses 6 and 7, and to GLOBAL bit 0, change no register and do not move `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| evt_tx_ovf_i | input | 1 | transmit overflow pulse |
| evt_tx_done_i | input | 1 | transmit done pulse |
| evt_mac_i | input | 1 | MAC event pulse |
| evt_rx_early_i | input | 1 | early receive pulse |
| evt_rx_done_i | input | 1 | receive done pulse |
| evt_rx_reject_i | input | 1 | receive reject pulse |
| reg_addr_i | input | 3 | register address for read and write |
| reg_we_i | input | 1 | write strobe |
| reg_wdata_i | input | 8 | write data |
| reg_rdata_o | output | 8 | read data for reg_addr_i |
| irq_o | output | 1 | host interrupt line |

## Verification
The hardest case to reach from the ports is a status clear that meets a new event on the same bit in the same cycle. The bench lines up the write strobe and the event pulse on one edge and checks that the bit stays set. The second hard case is the acknowledge flag outliving its cause: the bench clears every status bit while the flag is held and checks that the line stays up until SERVICE is written. A long random phase mixes writes to all addresses, including the unmapped ones, with random event pulses. Throughout, a behavioural model is compared with the line and the read data on every clock.

// File: rtl/eia_pkg.sv
package eia_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  localparam int BIT_TXOVF   = 0;
  localparam int BIT_TXDONE  = 1;
  localparam int BIT_MAC     = 2;
  localparam int BIT_RXEARLY = 4;
  localparam int BIT_RXDONE  = 5;
  localparam int BIT_RXREJ   = 6;
  localparam int BIT_FORCE   = 7;

  localparam logic [DATA_W-1:0] SRC_IMPL = 8'hF7;

  localparam int CMD_EN_BIT    = 2;
  localparam int CMD_FORCE_BIT = 3;
  localparam int GLB_PEND_BIT  = 0;
  localparam int GLB_MASK_BIT  = 1;
  localparam int CFG_LEVEL_BIT = 0;
  localparam int CFG_ACK_BIT   = 1;
  localparam int SVC_FLAG_BIT  = 0;

  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS  = 3'd0,
    RA_ENABLE  = 3'd1,
    RA_CMD     = 3'd2,
    RA_GLOBAL  = 3'd3,
    RA_CFG     = 3'd4,
    RA_SERVICE = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic ack_req;
    logic level;
  } irq_cfg_t;
endpackage

// File: rtl/eia_status_bank.sv
module eia_status_bank
  import eia_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter logic [W-1:0] IMPL = SRC_IMPL
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_d_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         any_o
);
  logic [W-1:0] status_q;
  logic [W-1:0] enable_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (IMPL[g]) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          status_q[g] <= 1'b0;
          enable_q[g] <= 1'b0;
        end else begin
          status_q[g] <= (status_q[g] & ~clr_i[g]) | set_i[g];
          if (en_we_i) enable_q[g] <= en_d_i[g];
        end
      end
    end else begin : g_hole
      logic unused_hole;
      assign unused_hole = ^{set_i[g], clr_i[g], en_d_i[g]};
      assign status_q[g] = 1'b0;
      assign enable_q[g] = 1'b0;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign any_o    = |(status_q & enable_q);

  p_set_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & IMPL) != '0) |=>
      ((status_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  p_clear_takes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i & IMPL) != '0) |=>
      ((status_o & $past(clr_i & ~set_i & IMPL)) == '0));

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_o) & ~$past(clr_i) & ~status_o) == '0));
endmodule

// File: rtl/eia_host_ctrl.sv
module eia_host_ctrl
  import eia_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     any_i,
  input  logic     gen_we_i,
  input  logic     gen_d_i,
  input  logic     gmask_we_i,
  input  logic     gmask_d_i,
  input  logic     cfg_we_i,
  input  irq_cfg_t cfg_d_i,
  input  logic     svc_clr_i,
  output logic     gen_o,
  output logic     gmask_o,
  output irq_cfg_t cfg_o,
  output logic     pend_o,
  output logic     svc_o,
  output logic     req_o
);
  logic     gen_q, gmask_q, svc_q;
  irq_cfg_t cfg_q;
  logic     host_req;

  assign pend_o   = gen_q & any_i;
  assign host_req = pend_o & ~gmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q   <= 1'b0;
      gmask_q <= 1'b0;
      cfg_q   <= '0;
      svc_q   <= 1'b0;
    end else begin
      if (gen_we_i)   gen_q   <= gen_d_i;
      if (gmask_we_i) gmask_q <= gmask_d_i;
      if (cfg_we_i)   cfg_q   <= cfg_d_i;
      if (cfg_q.ack_req) svc_q <= (svc_q & ~svc_clr_i) | host_req;
      else               svc_q <= 1'b0;
    end
  end

  assign gen_o   = gen_q;
  assign gmask_o = gmask_q;
  assign cfg_o   = cfg_q;
  assign svc_o   = svc_q;
  assign req_o   = cfg_q.ack_req ? svc_q : host_req;

  p_svc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.ack_req && svc_q && !svc_clr_i) |=> svc_o);

  p_svc_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.ack_req && pend_o && !gmask_o) |=> svc_o);

  p_gmask_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gmask_o && !cfg_o.ack_req) |-> !req_o);
endmodule

// File: rtl/eia_line_gen.sv
module eia_line_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic req_i,
  output logic irq_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= req_i;
  end

  assign irq_o = level_i ? req_i : (req_i & ~prev_q);

  p_edge_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && irq_o) |=> (level_i || !irq_o));
endmodule

// File: rtl/eth_irq_aggregator.sv
module eth_irq_aggregator
  import eia_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_tx_ovf_i,
  input  logic          evt_tx_done_i,
  input  logic          evt_mac_i,
  input  logic          evt_rx_early_i,
  input  logic          evt_rx_done_i,
  input  logic          evt_rx_reject_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_we_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic [DW-1:0] set_vec, clr_vec, status, enable;
  logic          any_src, gen, gmask, pend, svc, req;
  irq_cfg_t      cfg, cfg_d;
  logic          we_status, we_enable, we_cmd, we_global, we_cfg, we_svc;

  assign we_status = reg_we_i && (reg_addr_i == AW'(RA_STATUS));
  assign we_enable = reg_we_i && (reg_addr_i == AW'(RA_ENABLE));
  assign we_cmd    = reg_we_i && (reg_addr_i == AW'(RA_CMD));
  assign we_global = reg_we_i && (reg_addr_i == AW'(RA_GLOBAL));
  assign we_cfg    = reg_we_i && (reg_addr_i == AW'(RA_CFG));
  assign we_svc    = reg_we_i && (reg_addr_i == AW'(RA_SERVICE));

  always_comb begin
    set_vec              = '0;
    set_vec[BIT_TXOVF]   = evt_tx_ovf_i;
    set_vec[BIT_TXDONE]  = evt_tx_done_i;
    set_vec[BIT_MAC]     = evt_mac_i;
    set_vec[BIT_RXEARLY] = evt_rx_early_i;
    set_vec[BIT_RXDONE]  = evt_rx_done_i;
    set_vec[BIT_RXREJ]   = evt_rx_reject_i;
    set_vec[BIT_FORCE]   = we_cmd & reg_wdata_i[CMD_FORCE_BIT];
  end

  assign clr_vec       = we_status ? reg_wdata_i : '0;
  assign cfg_d.level   = reg_wdata_i[CFG_LEVEL_BIT];
  assign cfg_d.ack_req = reg_wdata_i[CFG_ACK_BIT];

  eia_status_bank #(.W(DW), .IMPL(SRC_IMPL)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .en_we_i  (we_enable),
    .en_d_i   (reg_wdata_i),
    .status_o (status),
    .enable_o (enable),
    .any_o    (any_src)
  );

  eia_host_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_i      (any_src),
    .gen_we_i   (we_cmd),
    .gen_d_i    (reg_wdata_i[CMD_EN_BIT]),
    .gmask_we_i (we_global),
    .gmask_d_i  (reg_wdata_i[GLB_MASK_BIT]),
    .cfg_we_i   (we_cfg),
    .cfg_d_i    (cfg_d),
    .svc_clr_i  (we_svc & reg_wdata_i[SVC_FLAG_BIT]),
    .gen_o      (gen),
    .gmask_o    (gmask),
    .cfg_o      (cfg),
    .pend_o     (pend),
    .svc_o      (svc),
    .req_o      (req)
  );

  eia_line_gen u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (cfg.level),
    .req_i   (req),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(RA_STATUS):  reg_rdata_o = status;
      AW'(RA_ENABLE):  reg_rdata_o = enable;
      AW'(RA_CMD):     reg_rdata_o[CMD_EN_BIT] = gen;
      AW'(RA_GLOBAL): begin
        reg_rdata_o[GLB_PEND_BIT] = pend;
        reg_rdata_o[GLB_MASK_BIT] = gmask;
      end
      AW'(RA_CFG): begin
        reg_rdata_o[CFG_LEVEL_BIT] = cfg.level;
        reg_rdata_o[CFG_ACK_BIT]   = cfg.ack_req;
      end
      AW'(RA_SERVICE): reg_rdata_o[SVC_FLAG_BIT] = svc;
      default:         reg_rdata_o = '0;
    endcase
  end

  p_gmask_silences_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gmask && !cfg.ack_req) |-> !irq_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen && !svc) |-> !irq_o);
endmodule

// File: tb/eth_irq_aggregator_tb.sv
module eth_irq_aggregator_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] evt = '0;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int compared = 0;
  int mismatched = 0;
  bit cmp_on = 1'b0;
  string cur_tag = "R1";
  int pulse_cnt = 0;

  always #5 clk = ~clk;

  eth_irq_aggregator u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_tx_ovf_i(evt[0]), .evt_tx_done_i(evt[1]), .evt_mac_i(evt[2]),
    .evt_rx_early_i(evt[3]), .evt_rx_done_i(evt[4]), .evt_rx_reject_i(evt[5]),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [7:0] m_st, m_en_mask;
  bit m_gen, m_gm, m_lvl, m_ack, m_svc, m_prev;
  int ev_pos[6] = '{0, 1, 2, 4, 5, 6};

  function automatic bit m_pend();
    return m_gen && ((m_st & m_en_mask) != 0);
  endfunction
  function automatic bit m_host();
    return m_pend() && !m_gm;
  endfunction
  function automatic bit m_req();
    return m_ack ? m_svc : m_host();
  endfunction
  function automatic bit m_irq();
    return m_lvl ? m_req() : (m_req() && !m_prev);
  endfunction
  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_st;
      3'd1: return m_en_mask;
      3'd2: return {5'b0, m_gen, 2'b0};
      3'd3: return {6'b0, m_gm, m_pend()};
      3'd4: return {6'b0, m_ack, m_lvl};
      3'd5: return {7'b0, m_svc};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_en_mask = 0; m_gen = 0; m_gm = 0;
      m_lvl = 0; m_ack = 0; m_svc = 0; m_prev = 0;
    end else begin
      logic [7:0] ev, clr, n_st;
      bit n_svc, n_prev;
      ev = 0;
      foreach (ev_pos[i]) if (evt[i]) ev[ev_pos[i]] = 1'b1;
      if (we && addr == 3'd2 && wdata[3]) ev[7] = 1'b1;
      clr = (we && addr == 3'd0) ? wdata : 8'h00;
      n_st = ((m_st & ~clr) | ev) & 8'hF7;
      n_svc = m_ack ? ((m_svc && !(we && addr == 3'd5 && wdata[0])) || m_host()) : 1'b0;
      n_prev = m_req();
      m_st = n_st; m_svc = n_svc; m_prev = n_prev;
      if (we && addr == 3'd1) m_en_mask = wdata & 8'hF7;
      if (we && addr == 3'd2) m_gen = wdata[2];
      if (we && addr == 3'd3) m_gm = wdata[1];
      if (we && addr == 3'd4) begin m_lvl = wdata[0]; m_ack = wdata[1]; end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({cur_tag, " irq"}, {7'b0, irq}, {7'b0, m_irq()});
      chk({cur_tag, " rdata"}, rdata, m_read(addr));
    end
    if (irq) pulse_cnt++;
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; we = 1'b1; wdata = d; tick(); we = 1'b0; wdata = 8'h00;
  endtask
  task automatic pulse(input int idx);
    evt[idx] = 1'b1; tick(); evt = '0;
  endtask
  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr = a; @(negedge clk); chk(tag, rdata, exp); tick();
  endtask
  task automatic irq_chk(input bit exp, input string tag);
    @(negedge clk); chk(tag, {7'b0, irq}, {7'b0, exp}); tick();
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    cmp_on = 1'b1;

    cur_tag = "R1";
    for (int a = 0; a < 6; a++) rd_chk(3'(a), 8'h00, "R1 reset read");
    irq_chk(1'b0, "R1 reset irq");

    cur_tag = "R2";
    wr(3'd4, 8'h01);
    for (int i = 0; i < 6; i++) pulse(i);
    rd_chk(3'd0, 8'h77, "R2 status layout");

    cur_tag = "R3";
    wr(3'd0, 8'h05);
    rd_chk(3'd0, 8'h72, "R3 w1c");
    addr = 3'd0; we = 1'b1; wdata = 8'h20; evt[4] = 1'b1; tick();
    we = 1'b0; wdata = 0; evt = '0;
    rd_chk(3'd0, 8'h72, "R3 set wins over clear");

    cur_tag = "R10";
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF); wr(3'd3, 8'h01);
    rd_chk(3'd0, 8'h72, "R10 status untouched");
    rd_chk(3'd1, 8'h00, "R10 enable untouched");
    rd_chk(3'd3, 8'h00, "R10 pending read-only");
    irq_chk(1'b0, "R10 irq quiet");

    cur_tag = "R4";
    wr(3'd1, 8'hFF);
    rd_chk(3'd1, 8'hF7, "R4 enable readback");
    wr(3'd1, 8'h20);
    rd_chk(3'd3, 8'h00, "R4 no pending while disabled");
    cur_tag = "R5";
    wr(3'd2, 8'hF4);
    rd_chk(3'd2, 8'h04, "R5 enable readback");
    rd_chk(3'd0, 8'h72, "R5 no force without bit3");
    cur_tag = "R7";
    rd_chk(3'd3, 8'h01, "R4 pending");
    irq_chk(1'b1, "R7 level high");

    cur_tag = "R6";
    wr(3'd3, 8'h02);
    irq_chk(1'b0, "R6 masked");
    rd_chk(3'd3, 8'h03, "R6 global readback");
    wr(3'd3, 8'h00);
    irq_chk(1'b1, "R6 unmasked");

    cur_tag = "R7";
    wr(3'd0, 8'hFF);
    irq_chk(1'b0, "R7 level drops");

    cur_tag = "R5";
    wr(3'd1, 8'h80);
    wr(3'd2, 8'h0C);
    rd_chk(3'd0, 8'h80, "R5 force sets bit7");
    irq_chk(1'b1, "R5 forced irq");
    wr(3'd0, 8'hFF);

    cur_tag = "R8";
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h01);
    pulse_cnt = 0;
    pulse(0);
    repeat (5) tick();
    pulse(0);
    repeat (5) tick();
    chk("R8 single pulse", 8'(pulse_cnt), 8'd1);
    wr(3'd0, 8'hFF);
    repeat (2) tick();
    pulse(0);
    repeat (3) tick();
    chk("R8 pulse after re-arm", 8'(pulse_cnt), 8'd2);
    wr(3'd0, 8'hFF);

    cur_tag = "R9";
    wr(3'd4, 8'h03);
    pulse(0);
    tick();
    rd_chk(3'd5, 8'h01, "R9 flag set");
    wr(3'd0, 8'hFF);
    irq_chk(1'b1, "R9 held after status clear");
    rd_chk(3'd5, 8'h01, "R9 flag held");
    wr(3'd5, 8'h01);
    irq_chk(1'b0, "R9 released by ack");
    rd_chk(3'd5, 8'h00, "R9 flag cleared");

    cur_tag = "RND";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      evt = 6'($urandom) & 6'($urandom);
      addr = 3'($urandom);
      if (r < 4) begin
        we = 1'b1;
        wdata = 8'($urandom);
        if (addr == 3'd4 && r != 0) we = 1'b0;
      end
      tick();
      we = 1'b0; wdata = 0; evt = '0;
    end
    tick();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule